// File: doc/BRIEF.md
# Two-Wire Control Register Target

This block lets a host controller on a two-wire serial bus (I2C protocol) load and inspect a small bank of byte-wide control registers. The target answers to one 7-bit device address. After that address, a write carries a 16-bit register pointer, low byte first, and then any number of data bytes. Each data byte lands at the pointer, and the pointer then steps by one.

To read, the host first performs a write that carries only the pointer, then a STOP. It then opens a new transfer with the read direction bit set. Bytes come out starting at the stored pointer, and the pointer advances past each byte sent.

The bank holds two windows: six display-overlay registers and sixteen amplifier-setup registers. All bytes are exposed in parallel for the surrounding logic. One bit in the bank is a self-clearing command that restores every register to its power-on value.

Top module: `ctl_i2c_target`

## Requirements
- R1: The target acknowledges only the device byte 0xBA (write) or 0xBB (read), i.e. 7-bit address 0x5D plus the direction bit in bit 0. Any other device byte is not acknowledged, and SDA stays released until the next START.
- R2: In a write, the two bytes after the device byte form the register pointer, low byte first. The target acknowledges each of them by pulling SDA low in the ninth clock.
- R3: Each further write byte is stored at the pointer, and the pointer then increments, so a burst fills consecutive registers.
- R4: A read returns the byte at the stored pointer, most significant bit first, and increments the pointer after every byte sent. The increment also carries across separate read transfers.
- R5: After reset, reg_flat_o holds the register at 0x0800 in bits [7:0], rising by one byte per register through 0x0805, then 0x0810 through 0x081F. The reset values are: 0x0800..0x0805 = 00,00,D0,CC,04,10; 0x0810..0x0813 = E0; 0x0814..0x0817 = 80; 0x0818 = 94; 0x0819 = 00; 0x081E = 16; all others 00.
- R6: Writing a byte with bit 0 set to 0x081F makes every register take its reset value on the following cycle. That bit then reads 0, and bits 7:1 of 0x081F always read 0. The transfer in progress continues and is still acknowledged.
- R7: Bits 7:2 of 0x0819 are a read-only identifier, with value 0 by default. Writes change only bits 1:0.
- R8: Pointer values outside 0x0800..0x0805 and 0x0810..0x081F read as 0x00. Writes to them change no register, but each data byte is still acknowledged.
- R9: When the host answers a read byte with NACK, the target releases SDA and stays released until the next START.
- R10: sda_oe_o is low after reset, and it changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | High pulls the data line low (open drain) |
| reg_flat_o | output | 176 | All registers side by side, 0x0800 in the low byte |

## Verification
The checks on output-enable edges assume the host changes SDA only while SCL has been low for several clock cycles, except for START and STOP. The bench keeps every SCL phase at least four clocks long, far longer than the synchronizer delay. The reload check assumes no register write arrives on the cycle after a reset command. This holds because writes are at least nine SCL periods apart. The bench compares every register against its model on each clock between transfers, and checks acknowledge bits and read data at the SDA pin.

// File: rtl/ctl_i2c_pkg.sv
package ctl_i2c_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DEV,
    S_DEV_ACK,
    S_RX,
    S_RX_ACK,
    S_TX,
    S_TX_ACK
  } i2c_state_e;

  // Power-on value of register slot idx (overlay window first, then setup window)
  function automatic logic [7:0] reg_default(input int idx, input int osd_n,
                                             input logic [5:0] die);
    int p;
    logic [7:0] v;
    v = 8'h00;
    if (idx < osd_n) begin
      case (idx)
        2:       v = 8'hD0;
        3:       v = 8'hCC;
        4:       v = 8'h04;
        5:       v = 8'h10;
        default: v = 8'h00;
      endcase
    end else begin
      p = idx - osd_n;
      if (p < 4)       v = 8'hE0;
      else if (p < 8)  v = 8'h80;
      else if (p == 8) v = 8'h94;
      else if (p == 9) v = {die, 2'b00};
      else if (p == 14) v = 8'h16;
      else             v = 8'h00;
    end
    return v;
  endfunction

endpackage

// File: rtl/ctl_i2c_linesync.sv
module ctl_i2c_linesync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  // bit STAGES-1 is the synchronised level, bit STAGES its previous value
  logic [STAGES:0] scl_q;
  logic [STAGES:0] sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[STAGES-1:0], scl_i};
      sda_q <= {sda_q[STAGES-1:0], sda_i};
    end
  end

  logic scl_now, scl_old, sda_now, sda_old;
  assign scl_now = scl_q[STAGES-1];
  assign scl_old = scl_q[STAGES];
  assign sda_now = sda_q[STAGES-1];
  assign sda_old = sda_q[STAGES];

  assign sda_o   = sda_now;
  assign start_o = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_o  = scl_now & scl_old & ~sda_old & sda_now;
  assign rise_o  = scl_now & ~scl_old;
  assign fall_o  = ~scl_now & scl_old;
endmodule

// File: rtl/ctl_i2c_engine.sv
module ctl_i2c_engine
  import ctl_i2c_pkg::*;
#(
  parameter int         AW       = 16,
  parameter logic [6:0] DEV_ADDR = 7'h5D
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sda_s,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic [7:0]    rd_data_i,
  output logic [AW-1:0] ptr_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          sda_oe_o
);
  i2c_state_e    state;
  logic [7:0]    sh;
  logic [7:0]    txsh;
  logic [2:0]    bcnt;
  logic          done;
  logic          rw;
  logic [1:0]    phase;
  logic [AW-1:0] ptr;
  logic          oe;
  logic [7:0]    nxt;

  assign nxt      = {sh[6:0], sda_s};
  assign ptr_o    = ptr;
  assign sda_oe_o = oe;

  always_ff @(posedge clk) begin
    wr_en_o <= 1'b0;
    if (rst) begin
      state     <= S_IDLE;
      sh        <= '0;
      txsh      <= '0;
      bcnt      <= '0;
      done      <= 1'b0;
      rw        <= 1'b0;
      phase     <= '0;
      ptr       <= '0;
      oe        <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else if (start_i) begin
      state <= S_DEV;
      bcnt  <= '0;
      done  <= 1'b0;
      oe    <= 1'b0;
      phase <= '0;
    end else if (stop_i) begin
      state <= S_IDLE;
      oe    <= 1'b0;
      done  <= 1'b0;
    end else begin
      case (state)
        S_DEV: begin
          if (rise_i) begin
            sh   <= nxt;
            bcnt <= bcnt + 3'd1;
            if (bcnt == 3'd7) done <= 1'b1;
          end else if (fall_i && done) begin
            done <= 1'b0;
            if (sh[7:1] == DEV_ADDR) begin
              oe    <= 1'b1;
              rw    <= sh[0];
              state <= S_DEV_ACK;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        S_DEV_ACK: begin
          if (fall_i) begin
            bcnt <= '0;
            if (rw) begin
              txsh  <= rd_data_i;
              oe    <= ~rd_data_i[7];
              ptr   <= ptr + 1'b1;
              state <= S_TX;
            end else begin
              oe    <= 1'b0;
              state <= S_RX;
            end
          end
        end
        S_RX: begin
          if (rise_i) begin
            sh   <= nxt;
            bcnt <= bcnt + 3'd1;
            if (bcnt == 3'd7) begin
              done <= 1'b1;
              case (phase)
                2'd0: begin
                  ptr[7:0] <= nxt;
                  phase    <= 2'd1;
                end
                2'd1: begin
                  ptr[AW-1:8] <= nxt[AW-9:0];
                  phase       <= 2'd2;
                end
                default: begin
                  wr_en_o   <= 1'b1;
                  wr_addr_o <= ptr;
                  wr_data_o <= nxt;
                  ptr       <= ptr + 1'b1;
                end
              endcase
            end
          end else if (fall_i && done) begin
            done  <= 1'b0;
            oe    <= 1'b1;
            state <= S_RX_ACK;
          end
        end
        S_RX_ACK: begin
          if (fall_i) begin
            oe    <= 1'b0;
            state <= S_RX;
          end
        end
        S_TX: begin
          if (fall_i) begin
            if (bcnt == 3'd7) begin
              oe    <= 1'b0;
              state <= S_TX_ACK;
            end else begin
              txsh <= {txsh[6:0], 1'b0};
              oe   <= ~txsh[6];
              bcnt <= bcnt + 3'd1;
            end
          end
        end
        S_TX_ACK: begin
          if (rise_i) begin
            if (sda_s) state <= S_IDLE;
            else       done  <= 1'b1;
          end else if (fall_i && done) begin
            done  <= 1'b0;
            bcnt  <= '0;
            txsh  <= rd_data_i;
            oe    <= ~rd_data_i[7];
            ptr   <= ptr + 1'b1;
            state <= S_TX;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ctl_i2c_regbank.sv
module ctl_i2c_regbank
  import ctl_i2c_pkg::*;
#(
  parameter int            AW       = 16,
  parameter logic [AW-1:0] OSD_BASE = 16'h0800,
  parameter int            OSD_N    = 6,
  parameter logic [AW-1:0] PRE_BASE = 16'h0810,
  parameter int            PRE_N    = 16,
  parameter logic [5:0]    DIE_ID   = 6'h00
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en_i,
  input  logic [AW-1:0]                wr_addr_i,
  input  logic [7:0]                   wr_data_i,
  input  logic [AW-1:0]                rd_addr_i,
  output logic [7:0]                   rd_data_o,
  output logic [(OSD_N+PRE_N)*8-1:0]   flat_o
);
  localparam int NREG     = OSD_N + PRE_N;
  localparam int IW       = $clog2(NREG);
  localparam int DIE_IDX  = OSD_N + 9;
  localparam int SRST_IDX = OSD_N + 15;

  // result: {hit, slot}
  function automatic logic [IW:0] decode(input logic [AW-1:0] a);
    logic [AW-1:0] o1, o2;
    o1 = a - OSD_BASE;
    o2 = a - PRE_BASE;
    if (a >= OSD_BASE && o1 < AW'(OSD_N))
      return {1'b1, IW'(o1)};
    else if (a >= PRE_BASE && o2 < AW'(PRE_N))
      return {1'b1, IW'(o2 + AW'(OSD_N))};
    return '0;
  endfunction

  logic [7:0]  mem [NREG];
  logic [IW:0] wdec, rdec;
  logic [7:0]  wval;

  always_comb begin
    wdec = decode(wr_addr_i);
    rdec = decode(rd_addr_i);
    wval = wr_data_i;
    if (wdec[IW-1:0] == IW'(DIE_IDX))
      wval = {DIE_ID, wr_data_i[1:0]};
    else if (wdec[IW-1:0] == IW'(SRST_IDX))
      wval = {7'b0, wr_data_i[0]};
  end

  always_ff @(posedge clk) begin
    if (rst || mem[SRST_IDX][0]) begin
      for (int i = 0; i < NREG; i++) mem[i] <= reg_default(i, OSD_N, DIE_ID);
    end else if (wr_en_i && wdec[IW]) begin
      mem[wdec[IW-1:0]] <= wval;
    end
  end

  assign rd_data_o = rdec[IW] ? mem[rdec[IW-1:0]] : 8'h00;

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign flat_o[g*8 +: 8] = mem[g];
  end
endmodule

// File: rtl/ctl_i2c_target.sv
module ctl_i2c_target #(
  parameter logic [6:0]  DEV_ADDR = 7'h5D,
  parameter int          SYNC_STG = 2,
  parameter logic [15:0] OSD_BASE = 16'h0800,
  parameter int          OSD_N    = 6,
  parameter logic [15:0] PRE_BASE = 16'h0810,
  parameter int          PRE_N    = 16,
  parameter logic [5:0]  DIE_ID   = 6'h00
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_oe_o,
  output logic [(OSD_N+PRE_N)*8-1:0] reg_flat_o
);
  localparam int AW = 16;

  logic          sda_s, start_p, stop_p, rise_p, fall_p;
  logic [7:0]    rd_data;
  logic [AW-1:0] ptr;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;

  ctl_i2c_linesync #(.STAGES(SYNC_STG)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .scl_i  (scl_i),
    .sda_i  (sda_i),
    .sda_o  (sda_s),
    .start_o(start_p),
    .stop_o (stop_p),
    .rise_o (rise_p),
    .fall_o (fall_p)
  );

  ctl_i2c_engine #(.AW(AW), .DEV_ADDR(DEV_ADDR)) u_eng (
    .clk      (clk),
    .rst      (rst),
    .sda_s    (sda_s),
    .start_i  (start_p),
    .stop_i   (stop_p),
    .rise_i   (rise_p),
    .fall_i   (fall_p),
    .rd_data_i(rd_data),
    .ptr_o    (ptr),
    .wr_en_o  (wr_en),
    .wr_addr_o(wr_addr),
    .wr_data_o(wr_data),
    .sda_oe_o (sda_oe_o)
  );

  ctl_i2c_regbank #(
    .AW(AW), .OSD_BASE(OSD_BASE), .OSD_N(OSD_N),
    .PRE_BASE(PRE_BASE), .PRE_N(PRE_N), .DIE_ID(DIE_ID)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .rd_addr_i(ptr),
    .rd_data_o(rd_data),
    .flat_o   (reg_flat_o)
  );
endmodule

// File: rtl/ctl_i2c_target_chk.sv
module ctl_i2c_target_chk
  import ctl_i2c_pkg::*;
#(
  parameter int         OSD_N  = 6,
  parameter int         PRE_N  = 16,
  parameter logic [5:0] DIE_ID = 6'h00
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       scl_i,
  input logic                       sda_oe_o,
  input logic [(OSD_N+PRE_N)*8-1:0] reg_flat_o
);
  localparam int NREG     = OSD_N + PRE_N;
  localparam int DIE_LSB  = (OSD_N + 9) * 8 + 2;
  localparam int SRST_BIT = (OSD_N + 15) * 8;

  logic [NREG*8-1:0] dflt;
  always_comb begin
    for (int i = 0; i < NREG; i++) dflt[i*8 +: 8] = reg_default(i, OSD_N, DIE_ID);
  end

  // R6
  srst_reload_chk: assert property (@(posedge clk) disable iff (rst)
    reg_flat_o[SRST_BIT] |=> (reg_flat_o == dflt));

  // R7
  die_id_chk: assert property (@(posedge clk) disable iff (rst)
    reg_flat_o[DIE_LSB +: 6] == DIE_ID);

  // R10
  oe_edge_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_oe_o) || $fell(sda_oe_o)) |-> !scl_i);

  // R10
  oe_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !sda_oe_o);

  // R6
  srst_bit_clear_chk: assert property (@(posedge clk) disable iff (rst)
    reg_flat_o[SRST_BIT] |=> !reg_flat_o[SRST_BIT]);
endmodule

bind ctl_i2c_target ctl_i2c_target_chk #(
  .OSD_N(OSD_N), .PRE_N(PRE_N), .DIE_ID(DIE_ID)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .scl_i     (scl_i),
  .sda_oe_o  (sda_oe_o),
  .reg_flat_o(reg_flat_o)
);

// File: tb/ctl_i2c_target_bench.sv
module ctl_i2c_target_bench;
  localparam int NREG = 22;
  localparam int Q    = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe;
  logic sda_bus;
  logic [NREG*8-1:0] flat;

  always #4 clk = ~clk;

  assign sda_bus = !(sda_oe || m_low);

  ctl_i2c_target u_ctl_i2c_target (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (m_scl),
    .sda_i     (sda_bus),
    .sda_oe_o  (sda_oe),
    .reg_flat_o(flat)
  );

  int vecs = 0;
  int errs = 0;
  logic cmp_en = 1'b0;
  logic finished = 1'b0;
  logic [7:0] model [NREG];
  logic [7:0] wq[$];
  logic [7:0] rq[$];

  function automatic logic [7:0] dflt_of(input int a);
    case (a)
      'h0802: return 8'hD0;
      'h0803: return 8'hCC;
      'h0804: return 8'h04;
      'h0805: return 8'h10;
      'h0810, 'h0811, 'h0812, 'h0813: return 8'hE0;
      'h0814, 'h0815, 'h0816, 'h0817: return 8'h80;
      'h0818: return 8'h94;
      'h081E: return 8'h16;
      default: return 8'h00;
    endcase
  endfunction

  function automatic int slot_of(input int a);
    if (a >= 'h0800 && a <= 'h0805) return a - 'h0800;
    if (a >= 'h0810 && a <= 'h081F) return a - 'h0810 + 6;
    return -1;
  endfunction

  function automatic void model_reset();
    for (int a = 'h0800; a <= 'h081F; a++)
      if (slot_of(a) >= 0) model[slot_of(a)] = dflt_of(a);
  endfunction

  function automatic void model_write(input int a, input logic [7:0] v);
    if (slot_of(a) < 0) return;            // R8: discarded
    if (a == 'h0819) model[slot_of(a)] = {6'b0, v[1:0]};   // R7
    else if (a == 'h081F) begin
      if (v[0]) model_reset();             // R6
    end else model[slot_of(a)] = v;
  endfunction

  function automatic logic [NREG*8-1:0] model_flat();
    logic [NREG*8-1:0] f;
    for (int i = 0; i < NREG; i++) f[i*8 +: 8] = model[i];
    return f;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // per-clock register comparison against the model (R3, R5, R6, R7, R8)
  always @(negedge clk) begin
    if (cmp_en && !rst && !finished) begin
      vecs++;
      if (flat !== model_flat()) begin
        errs++;
        $display("FAIL R3/R5/R6/R7/R8 register image: actual 0x%0h expected 0x%0h",
                 flat, model_flat());
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0;
    tick(Q);
    m_scl = 1'b1;
    tick(2*Q);
    m_low = 1'b1;
    tick(2*Q);
    m_scl = 1'b0;
    tick(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1;
    tick(Q);
    m_scl = 1'b1;
    tick(2*Q);
    m_low = 1'b0;
    tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = !b[i];
      tick(Q);
      m_scl = 1'b1;
      tick(2*Q);
      m_scl = 1'b0;
      tick(Q);
    end
    m_low = 1'b0;
    tick(Q);
    m_scl = 1'b1;
    tick(Q);
    ack = !sda_bus;
    tick(Q);
    m_scl = 1'b0;
    tick(Q);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] d);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      m_scl = 1'b1;
      tick(Q);
      d[i] = sda_bus;
      tick(Q);
      m_scl = 1'b0;
      tick(Q);
    end
    m_low = !nack;
    tick(Q);
    m_scl = 1'b1;
    tick(2*Q);
    m_scl = 1'b0;
    tick(Q);
    m_low = 1'b0;
  endtask

  task automatic do_write(input int a, output logic ok);
    logic ack;
    cmp_en = 1'b0;
    ok = 1'b1;
    bus_start();
    send_byte(8'hBA, ack); ok &= ack;
    send_byte(a[7:0], ack); ok &= ack;
    send_byte(a[15:8], ack); ok &= ack;
    foreach (wq[i]) begin
      send_byte(wq[i], ack);
      ok &= ack;
    end
    bus_stop();
    foreach (wq[i]) model_write(a + i, wq[i]);
    tick(2);
    cmp_en = 1'b1;
  endtask

  task automatic set_ptr(input int a, output logic ok);
    logic ack;
    ok = 1'b1;
    bus_start();
    send_byte(8'hBA, ack); ok &= ack;
    send_byte(a[7:0], ack); ok &= ack;
    send_byte(a[15:8], ack); ok &= ack;
    bus_stop();
  endtask

  task automatic read_on(input int n, output logic ok);
    logic ack;
    logic [7:0] d;
    rq.delete();
    bus_start();
    send_byte(8'hBB, ack);
    ok = ack;
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, d);
      rq.push_back(d);
    end
    bus_stop();
  endtask

  task automatic read_at(input int a, input int n);
    logic ok1, ok2;
    set_ptr(a, ok1);
    read_on(n, ok2);
    check("R4 read setup acknowledged", int'(ok1 & ok2), 1);
  endtask

  initial begin
    logic ok, ack;
    logic [7:0] d;
    model_reset();
    tick(5);
    rst = 1'b0;
    tick(2);
    check("R5 reset register image", int'(flat === model_flat()), 1);
    check("R10 output enable low after reset", int'(sda_oe), 0);
    cmp_en = 1'b1;

    // R1: foreign device byte is ignored, line stays released
    bus_start();
    send_byte(8'hA0, ack);
    check("R1 foreign address not acknowledged", int'(ack), 0);
    send_byte(8'h10, ack);
    check("R1 released until next START", int'(ack), 0);
    bus_stop();

    // R2 / R3: burst into the gain registers
    wq = '{8'h11, 8'h22, 8'h33, 8'h44};
    do_write('h0810, ok);
    check("R2 R3 write burst acknowledged", int'(ok), 1);
    read_at('h0810, 4);
    check("R4 read byte 0", rq[0], 'h11);
    check("R4 read byte 1", rq[1], 'h22);
    check("R4 read byte 2", rq[2], 'h33);
    check("R4 read byte 3", rq[3], 'h44);

    // R3: overlay window increments
    wq = '{8'hA5, 8'h5A, 8'h3C};
    do_write('h0803, ok);
    check("R3 overlay burst acknowledged", int'(ok), 1);
    read_at('h0802, 4);
    check("R5 untouched overlay default", rq[0], 'hD0);
    check("R3 overlay 0x0803", rq[1], 'hA5);
    check("R3 overlay 0x0804", rq[2], 'h5A);
    check("R3 overlay 0x0805", rq[3], 'h3C);

    // R4: pointer carries over to the next read transfer
    wq = '{8'h01, 8'h02, 8'h03};
    do_write('h0814, ok);
    read_at('h0814, 1);
    check("R4 first read", rq[0], 'h01);
    read_on(2, ok);
    check("R4 continued read acknowledged", int'(ok), 1);
    check("R4 continued read 0x0815", rq[0], 'h02);
    check("R4 continued read 0x0816", rq[1], 'h03);

    // R7: identifier bits are read only
    wq = '{8'hFF};
    do_write('h0819, ok);
    read_at('h0819, 1);
    check("R7 identifier bits unchanged", rq[0], 'h03);

    // R8: unimplemented locations
    wq = '{8'h77};
    do_write('h0806, ok);
    check("R8 unimplemented write acknowledged", int'(ok), 1);
    read_at('h0806, 1);
    check("R8 gap reads zero", rq[0], 'h00);
    read_at('h0820, 1);
    check("R8 beyond window reads zero", rq[0], 'h00);

    // R9: host NACK releases the line
    set_ptr('h0810, ok);
    bus_start();
    send_byte(8'hBB, ack);
    recv_byte(1'b1, d);
    check("R9 byte before NACK", d, 'h11);
    send_byte(8'hFF, ack);
    check("R9 line released after NACK", int'(ack), 0);
    check("R9 output enable idle", int'(sda_oe), 0);
    bus_stop();

    // R6: soft reset mid-burst, transfer continues
    wq = '{8'h01, 8'h55};
    do_write('h081F, ok);
    check("R6 burst after reset command acknowledged", int'(ok), 1);
    read_at('h0810, 1);
    check("R6 gain back to default", rq[0], 'hE0);
    read_at('h081F, 1);
    check("R6 command bit cleared", rq[0], 'h00);
    read_at('h0805, 1);
    check("R6 overlay back to default", rq[0], 'h10);

    tick(4);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule